// File: doc/BRIEF.md
# Configurable-Frame Serial Transceiver with Hardware Handshake

This block is a full-duplex asynchronous serial transceiver clocked by the system clock and paced by a one-cycle enable pulse (`tick16`) that a baud generator issues sixteen times per bit period. On the transmit side it takes bytes through a valid/ready handshake and shifts them out on the line. On the receive side it recovers characters from the line and presents each one for a single cycle, together with its error flags. The frame shape is selected by static configuration inputs. Data length is 7 or 8 bits, there are 1 or 2 stop bits, and the parity mode is one of odd, even, forced-one, forced-zero or absent. Data travels least significant bit first, and the logical line idles high.

Every serial pin has its own polarity control. The transmitter starts a character only while the clear-to-send input is asserted. The request-to-send output drops whenever the downstream receive store reports that it is almost full. A transmit-enable output frames each transmitted character so that it can steer a half-duplex bus driver. The transmitter can hold the line in a break condition. The receiver recognises an all-zero frame as a break instead of a data byte.

The transmitter state machine has the states TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP and TX_BREAK. Its transitions are:
- IDLE to START when a byte is accepted.
- IDLE to BREAK on a break request.
- BREAK back to IDLE when the request is withdrawn.
- START to DATA.
- DATA to PARITY, or straight to STOP, after the last data bit.
- PARITY to STOP.
- STOP to STOP for a second stop bit.
- STOP to IDLE.

The receiver state machine has the states RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP and RX_WAIT_HIGH. Its transitions are:
- IDLE to START when a low line is seen.
- START to DATA when the mid-bit check confirms the start bit.
- START back to IDLE when that check finds a glitch.
- DATA to PARITY, or to STOP, after the last data bit.
- PARITY to STOP.
- STOP to IDLE on a good stop bit.
- STOP to WAIT_HIGH after a framing error or a break.
- WAIT_HIGH to IDLE once the line returns high.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, `txd_pin` sits at logical 1 (after polarity), `txden` is 0, and `rx_valid` and `rx_break` are 0.
- R2: A transmitted character consists of a start bit (0), then the data bits LSB first (7 bits when `cfg_seven`=1, otherwise 8), then the parity bit if one is enabled, then the stop bits (1). Each bit lasts exactly 16 `tick16` pulses.
- R3: `cfg_parity` encodes the parity mode as follows: 0 = none, 1 = odd (the data bits plus parity hold an odd number of ones), 2 = even, 3 = parity bit always 1, 4 = parity bit always 0. In 7-bit mode only the 7 data bits count.
- R4: `cfg_two_stop`=1 sends two stop bits and 0 sends one. The transmit-enable window therefore lasts (1 + data + parity + stop) × 16 ticks.
- R5: The receiver confirms the start bit at its 8th tick, samples every later bit 16 ticks after the previous sample, and then pulses `rx_valid` for one cycle with the byte in `rx_data`. In 7-bit mode `rx_data[7]` is 0.
- R6: A stop bit received as 0 sets `rx_ferr`, and a parity bit that disagrees with the selected mode sets `rx_perr`. Both flags are presented with the byte in the `rx_valid` cycle.
- R7: A frame whose start, data, parity and first stop bit all read 0 produces a one-cycle `rx_break` pulse and no `rx_valid`. After a break or a framing error, the receiver waits for the line to go high before it looks for a new start bit.
- R8: While `tx_break` is high and no character is in progress, the line is held at logical 0, `txden` stays 0 and no byte is accepted. A character that is already in progress finishes first.
- R9: Clear-to-send is asserted when `cts_pin` XOR `inv_cts` is 1. A new character starts only while it is asserted. Deasserting it in the middle of a character does not shorten that character.
- R10: `rts_pin` equals (NOT `rx_almost_full`) XOR `inv_rts`.
- R11: `txd_pin` is the logical line XOR `inv_txd`, and the receiver decodes `rxd_pin` XOR `inv_rxd`.
- R12: `txden` is high from the start of the start bit to the end of the last stop bit, and low otherwise, including during a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_parity | input | 3 | Parity mode code (see R3) |
| inv_txd | input | 1 | Invert transmit pin |
| inv_rxd | input | 1 | Invert receive pin |
| inv_rts | input | 1 | Invert request-to-send pin |
| inv_cts | input | 1 | Invert clear-to-send pin |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Byte accepted this cycle when valid |
| tx_break | input | 1 | Request to hold the line in break |
| txd_pin | output | 1 | Serial transmit pin |
| txden | output | 1 | Transmit enable for a bus driver |
| rxd_pin | input | 1 | Serial receive pin |
| rx_valid | output | 1 | One-cycle received-byte strobe |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error with this byte |
| rx_ferr | output | 1 | Framing error with this byte |
| rx_break | output | 1 | One-cycle break-detected strobe |
| rx_almost_full | input | 1 | Downstream store nearly full |
| rts_pin | output | 1 | Request-to-send pin |
| cts_pin | input | 1 | Clear-to-send pin |

## Verification
The hardest situation to reach is a clear-to-send drop or a break request that lands while a character is already on the line. It has to arrive at a known bit position, and the full frame length must still be measured afterwards. The stimulus reaches this by counting clocks from the rise of `txden` and toggling the pin at a fixed count inside the frame. It then measures the enable window to the exact cycle. The receiver's break and framing-error recovery are driven by a bench-built frame with a deliberately low stop bit, followed by a normal frame that must decode cleanly. Random configurations and bytes from a fixed seed cover the 7/8-bit, stop-length, parity and polarity combinations. The expected frames come from bench functions.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_ONE   = 3'd3,
        PAR_ZERO  = 3'd4
    } par_mode_e;

    // Parity bit that goes with a character under the given mode.
    function automatic logic parity_of(input logic [7:0] d,
                                       input logic       seven,
                                       input logic [2:0] mode);
        logic [7:0] m;
        m = seven ? {1'b0, d[6:0]} : d;
        case (mode)
            3'd1:    return ~^m;
            3'd2:    return ^m;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_xcvr_lines.sv
module uart_xcvr_lines #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_pin,
    input  logic inv_rxd,
    input  logic cts_pin,
    input  logic inv_cts,
    input  logic rx_almost_full,
    input  logic inv_rts,
    input  logic tx_line,
    input  logic inv_txd,
    output logic rx_line,
    output logic cts_ok,
    output logic rts_pin,
    output logic txd_pin
);

    logic [SYNC_STAGES-1:0] rx_sync_q;
    logic [SYNC_STAGES-1:0] cts_sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sync_q  <= '1;
            cts_sync_q <= '0;
        end else begin
            rx_sync_q[0]  <= rxd_pin ^ inv_rxd;
            cts_sync_q[0] <= cts_pin ^ inv_cts;
        end
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rx_sync_q[s]  <= 1'b1;
                cts_sync_q[s] <= 1'b0;
            end else begin
                rx_sync_q[s]  <= rx_sync_q[s-1];
                cts_sync_q[s] <= cts_sync_q[s-1];
            end
        end
    end

    assign rx_line = rx_sync_q[SYNC_STAGES-1];
    assign cts_ok  = cts_sync_q[SYNC_STAGES-1];
    assign rts_pin = (~rx_almost_full) ^ inv_rts;
    assign txd_pin = tx_line ^ inv_txd;

endmodule

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
    import uart_xcvr_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cfg_seven,
    input  logic       cfg_two_stop,
    input  logic [2:0] cfg_parity,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    input  logic       cts_ok,
    input  logic       brk_req,
    output logic       tx_ready,
    output logic       line,
    output logic       txden
);

    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_BIT - 1);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP, TX_BREAK
    } tx_state_e;

    tx_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [2:0]      idx_q, idx_d;
    logic            stop_q, stop_d;
    logic [7:0]      shreg_q, shreg_d;
    logic            par_q, par_d;

    logic       bit_end;
    logic       has_par;
    logic [2:0] last_idx;

    assign bit_end  = tick && (cnt_q == LAST_TICK);
    assign has_par  = (cfg_parity != 3'd0);
    assign last_idx = cfg_seven ? 3'd6 : 3'd7;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        stop_d  = stop_q;
        shreg_d = shreg_q;
        par_d   = par_q;
        if (tick) cnt_d = cnt_q + 1'b1;
        if (bit_end) cnt_d = '0;
        unique case (state_q)
            TX_IDLE: begin
                cnt_d = '0;
                if (brk_req) begin
                    state_d = TX_BREAK;
                end else if (tick && cts_ok && tx_valid) begin
                    state_d = TX_START;
                    shreg_d = tx_data;
                    par_d   = parity_of(tx_data, cfg_seven, cfg_parity);
                end
            end
            TX_BREAK: begin
                cnt_d = '0;
                if (!brk_req) state_d = TX_IDLE;
            end
            TX_START: begin
                if (bit_end) begin
                    state_d = TX_DATA;
                    idx_d   = 3'd0;
                end
            end
            TX_DATA: begin
                if (bit_end) begin
                    if (idx_q == last_idx) begin
                        state_d = has_par ? TX_PARITY : TX_STOP;
                        stop_d  = 1'b0;
                    end else begin
                        idx_d = idx_q + 3'd1;
                    end
                end
            end
            TX_PARITY: begin
                if (bit_end) begin
                    state_d = TX_STOP;
                    stop_d  = 1'b0;
                end
            end
            TX_STOP: begin
                if (bit_end) begin
                    if (cfg_two_stop && !stop_q) stop_d = 1'b1;
                    else                         state_d = TX_IDLE;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            stop_q  <= 1'b0;
            shreg_q <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            stop_q  <= stop_d;
            shreg_q <= shreg_d;
            par_q   <= par_d;
        end
    end

    always_comb begin
        line     = 1'b1;
        txden    = 1'b0;
        tx_ready = 1'b0;
        unique case (state_q)
            TX_IDLE:   tx_ready = tick && cts_ok && !brk_req;
            TX_BREAK:  line = 1'b0;
            TX_START:  begin line = 1'b0;           txden = 1'b1; end
            TX_DATA:   begin line = shreg_q[idx_q]; txden = 1'b1; end
            TX_PARITY: begin line = par_q;          txden = 1'b1; end
            TX_STOP:   begin line = 1'b1;           txden = 1'b1; end
            default:   line = 1'b1;
        endcase
    end

    assert_start_needs_cts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txden) |-> $past(cts_ok));
    assert_no_start_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txden) |-> !$past(brk_req));
    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txden) |-> !line);

endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
    import uart_xcvr_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cfg_seven,
    input  logic [2:0] cfg_parity,
    input  logic       line,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_break
);

    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(TICKS_PER_BIT / 2 - 1);

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_WAIT_HIGH
    } rx_state_e;

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [2:0]    idx_q, idx_d;
    logic [7:0]    shreg_q, shreg_d;
    logic          par_q, par_d;
    logic          ones_q, ones_d;

    logic       rep_valid, rep_break, rep_perr, rep_ferr;
    logic       sample;
    logic       has_par;
    logic [2:0] last_idx;

    assign sample   = tick && (cnt_q == LAST_TICK);
    assign has_par  = (cfg_parity != 3'd0);
    assign last_idx = cfg_seven ? 3'd6 : 3'd7;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        idx_d     = idx_q;
        shreg_d   = shreg_q;
        par_d     = par_q;
        ones_d    = ones_q;
        rep_valid = 1'b0;
        rep_break = 1'b0;
        rep_perr  = 1'b0;
        rep_ferr  = 1'b0;
        if (tick) cnt_d = cnt_q + 1'b1;
        if (sample) cnt_d = '0;
        unique case (state_q)
            RX_IDLE: begin
                cnt_d = '0;
                if (tick && !line) state_d = RX_START;
            end
            RX_START: begin
                if (tick && cnt_q == MID_TICK) begin
                    cnt_d = '0;
                    if (!line) begin
                        state_d = RX_DATA;
                        idx_d   = 3'd0;
                        shreg_d = '0;
                        ones_d  = 1'b0;
                    end else begin
                        state_d = RX_IDLE;
                    end
                end
            end
            RX_DATA: begin
                if (sample) begin
                    shreg_d[idx_q] = line;
                    ones_d         = ones_q | line;
                    if (idx_q == last_idx) state_d = has_par ? RX_PARITY : RX_STOP;
                    else                   idx_d   = idx_q + 3'd1;
                end
            end
            RX_PARITY: begin
                if (sample) begin
                    par_d   = line;
                    ones_d  = ones_q | line;
                    state_d = RX_STOP;
                end
            end
            RX_STOP: begin
                if (sample) begin
                    if (!line && !ones_q) begin
                        rep_break = 1'b1;
                        state_d   = RX_WAIT_HIGH;
                    end else begin
                        rep_valid = 1'b1;
                        rep_ferr  = !line;
                        rep_perr  = has_par &&
                                    (par_q != parity_of(shreg_q, cfg_seven, cfg_parity));
                        state_d   = line ? RX_IDLE : RX_WAIT_HIGH;
                    end
                end
            end
            RX_WAIT_HIGH: begin
                cnt_d = '0;
                if (line) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            ones_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            shreg_q <= shreg_d;
            par_q   <= par_d;
            ones_q  <= ones_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_break <= 1'b0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= rep_valid;
            rx_break <= rep_break;
            if (rep_valid) begin
                rx_data <= shreg_q;
                rx_perr <= rep_perr;
                rx_ferr <= rep_ferr;
            end
        end
    end

    assert_valid_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_seven_bit_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_seven) |-> !rx_data[7]);
    assert_break_without_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |-> !rx_valid);
    assert_ferr_waits_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ferr) |-> (state_q == RX_WAIT_HIGH));

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       cfg_seven,
    input  logic       cfg_two_stop,
    input  logic [2:0] cfg_parity,
    input  logic       inv_txd,
    input  logic       inv_rxd,
    input  logic       inv_rts,
    input  logic       inv_cts,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    input  logic       tx_break,
    output logic       txd_pin,
    output logic       txden,
    input  logic       rxd_pin,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_break,
    input  logic       rx_almost_full,
    output logic       rts_pin,
    input  logic       cts_pin
);

    logic tx_line;
    logic rx_line;
    logic cts_ok;

    uart_xcvr_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk            (clk),
        .rst_n          (rst_n),
        .rxd_pin        (rxd_pin),
        .inv_rxd        (inv_rxd),
        .cts_pin        (cts_pin),
        .inv_cts        (inv_cts),
        .rx_almost_full (rx_almost_full),
        .inv_rts        (inv_rts),
        .tx_line        (tx_line),
        .inv_txd        (inv_txd),
        .rx_line        (rx_line),
        .cts_ok         (cts_ok),
        .rts_pin        (rts_pin),
        .txd_pin        (txd_pin)
    );

    uart_xcvr_tx #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .cfg_seven    (cfg_seven),
        .cfg_two_stop (cfg_two_stop),
        .cfg_parity   (cfg_parity),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .cts_ok       (cts_ok),
        .brk_req      (tx_break),
        .tx_ready     (tx_ready),
        .line         (tx_line),
        .txden        (txden)
    );

    uart_xcvr_rx #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .cfg_seven  (cfg_seven),
        .cfg_parity (cfg_parity),
        .line       (rx_line),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_perr    (rx_perr),
        .rx_ferr    (rx_ferr),
        .rx_break   (rx_break)
    );

    assert_rts_drops_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_almost_full && !inv_rts) |-> !rts_pin);

endmodule

// File: tb/tb_uart_xcvr.sv
module tb_uart_xcvr;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, tick16;
    logic       cfg_seven, cfg_two_stop;
    logic [2:0] cfg_parity;
    logic       inv_txd, inv_rxd, inv_rts, inv_cts;
    logic       tx_valid, tx_ready, tx_break;
    logic [7:0] tx_data;
    logic       txd_pin, txden, rxd_pin;
    logic       rx_valid, rx_perr, rx_ferr, rx_break;
    logic [7:0] rx_data;
    logic       rx_almost_full, rts_pin, cts_pin;

    uart_xcvr dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cfg_seven(cfg_seven), .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity),
        .inv_txd(inv_txd), .inv_rxd(inv_rxd), .inv_rts(inv_rts), .inv_cts(inv_cts),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_break(tx_break),
        .txd_pin(txd_pin), .txden(txden), .rxd_pin(rxd_pin),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_break(rx_break), .rx_almost_full(rx_almost_full), .rts_pin(rts_pin),
        .cts_pin(cts_pin)
    );

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // 16x enable: one clock in four, driven just after the rising edge
    initial begin
        tick16 = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            tcnt   = (tcnt + 1) % 4;
            tick16 = (tcnt == 0);
        end
    end

    // receive monitor
    int n_valid = 0;
    int n_brk = 0;
    logic [7:0] got_d;
    logic got_pe, got_fe;
    always @(negedge clk) begin
        if (rx_valid) begin
            n_valid++;
            got_d  = rx_data;
            got_pe = rx_perr;
            got_fe = rx_ferr;
        end
        if (rx_break) n_brk++;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    // bench model of the frame
    function automatic logic exp_par(input logic [7:0] d, input logic n7, input logic [2:0] pm);
        int ones;
        ones = n7 ? $countones(d[6:0]) : $countones(d);
        case (pm)
            3'd1:    return (ones % 2) == 0;
            3'd2:    return (ones % 2) == 1;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    logic [11:0] fr_bits;
    int          fr_len;
    task automatic build_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int p;
        fr_bits = '0;
        fr_bits[0] = 1'b0;
        p = 1;
        for (int i = 0; i < (cfg_seven ? 7 : 8); i++) begin
            fr_bits[p] = d[i];
            p++;
        end
        if (cfg_parity != 3'd0) begin
            fr_bits[p] = exp_par(d, cfg_seven, cfg_parity) ^ bad_par;
            p++;
        end
        fr_bits[p] = !bad_stop;
        p++;
        if (cfg_two_stop) begin
            fr_bits[p] = 1'b1;
            p++;
        end
        fr_len = p;
    endtask

    task automatic set_cfg(input logic n7, input logic s2, input logic [2:0] pm,
                           input logic it, input logic ir, input logic irt, input logic ic);
        @(negedge clk);
        cfg_seven = n7; cfg_two_stop = s2; cfg_parity = pm;
        inv_txd = it; inv_rxd = ir; inv_rts = irt; inv_cts = ic;
        rxd_pin = 1'b1 ^ ir;
        cts_pin = 1'b1 ^ ic;
        repeat (8) @(negedge clk);
    endtask

    // send one byte and decode the line (R2 R3 R4 R12)
    task automatic send_tx(input logic [7:0] d, input bit drop_cts);
        logic [11:0] got;
        logic [11:0] mask;
        int k, w;
        build_frame(d, 1'b0, 1'b0);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        w = 0;
        while (!tx_ready && w < 5000) begin
            @(negedge clk);
            w++;
        end
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        got = '0;
        k = 0;
        while (txden && k < 1000) begin
            k++;
            if (drop_cts && k == 100) cts_pin = 1'b0 ^ inv_cts;
            if ((k % 64) == 32 && (k / 64) < 12) got[k/64] = txd_pin ^ inv_txd;
            @(negedge clk);
        end
        mask = (12'h1 << fr_len) - 12'h1;
        chk(k == fr_len * 64, "R4 R12 enable window", k, fr_len * 64);
        chk((got & mask) == fr_bits, "R2 R3 frame bits", int'(got & mask), int'(fr_bits));
        chk((txd_pin ^ inv_txd) == 1'b1, "R2 idle after stop", int'(txd_pin ^ inv_txd), 1);
        if (drop_cts) cts_pin = 1'b1 ^ inv_cts;
    endtask

    // drive one frame into the receiver (R5 R6 R7)
    task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                           input bit is_break);
        int v0, b0;
        logic [7:0] ed;
        v0 = n_valid;
        b0 = n_brk;
        if (is_break) begin
            fr_bits = '0;
            fr_len  = 12;
        end else begin
            build_frame(d, bad_par, bad_stop);
        end
        @(negedge clk);
        for (int i = 0; i < fr_len; i++) begin
            rxd_pin = fr_bits[i] ^ inv_rxd;
            repeat (64) @(negedge clk);
        end
        rxd_pin = 1'b1 ^ inv_rxd;
        repeat (128) @(negedge clk);
        ed = cfg_seven ? {1'b0, d[6:0]} : d;
        if (is_break) begin
            chk(n_brk == b0 + 1, "R7 break strobe", n_brk - b0, 1);
            chk(n_valid == v0, "R7 no byte on break", n_valid - v0, 0);
        end else begin
            chk(n_valid == v0 + 1, "R5 one byte", n_valid - v0, 1);
            chk(got_d == ed, "R5 R11 data", got_d, ed);
            chk(got_pe == (bad_par && cfg_parity != 3'd0), "R6 parity flag", got_pe,
                int'(bad_par && cfg_parity != 3'd0));
            chk(got_fe == bad_stop, "R6 framing flag", got_fe, int'(bad_stop));
        end
    endtask

    initial begin
        int unsigned seed;
        int hi;
        seed = $urandom(32'h5EED_0A17);
        rst_n = 1'b0;
        cfg_seven = 0; cfg_two_stop = 0; cfg_parity = 0;
        inv_txd = 0; inv_rxd = 0; inv_rts = 0; inv_cts = 0;
        tx_valid = 0; tx_data = 0; tx_break = 0;
        rxd_pin = 1; cts_pin = 1; rx_almost_full = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd_pin == 1'b1, "R1 txd idle", txd_pin, 1);
        chk(txden == 1'b0, "R1 txden", txden, 0);
        chk(rx_valid == 1'b0 && rx_break == 1'b0, "R1 rx strobes", {rx_valid, rx_break}, 0);

        // R10 request-to-send
        for (int c = 0; c < 4; c++) begin
            rx_almost_full = c[0];
            inv_rts = c[1];
            #1;
            chk(rts_pin == (!c[0] ^ c[1]), "R10 rts", rts_pin, int'(!c[0] ^ c[1]));
        end
        rx_almost_full = 0;
        inv_rts = 0;

        // R2 directed 8N1 and 7E2
        set_cfg(0, 0, 3'd0, 0, 0, 0, 0);
        send_tx(8'hA5, 0);
        set_cfg(1, 1, 3'd2, 0, 0, 0, 0);
        send_tx(8'hF3, 0);
        set_cfg(0, 0, 3'd3, 0, 0, 0, 0);
        send_tx(8'h00, 0);

        // R9 clear-to-send gating
        set_cfg(0, 0, 3'd1, 0, 0, 0, 0);
        cts_pin = 1'b0;
        tx_data = 8'h5A;
        tx_valid = 1'b1;
        hi = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (txden || !txd_pin) hi++;
        end
        chk(hi == 0, "R9 no start without cts", hi, 0);
        tx_valid = 1'b0;
        cts_pin = 1'b1;
        repeat (8) @(negedge clk);
        send_tx(8'h5A, 0);
        send_tx(8'h81, 1);   // R9 drop mid-frame, frame still full length

        // R8 break generation
        tx_break = 1'b1;
        tx_valid = 1'b1;
        repeat (4) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd_pin || txden || tx_ready) hi++;
        end
        chk(hi == 0, "R8 break holds line low", hi, 0);
        tx_valid = 1'b0;
        tx_break = 1'b0;
        repeat (8) @(negedge clk);
        chk(txd_pin == 1'b1, "R8 line released", txd_pin, 1);
        send_tx(8'h3C, 0);

        // R5 R6 R7 receiver directed
        set_cfg(0, 0, 3'd0, 0, 0, 0, 0);
        send_rx(8'h3C, 0, 0, 0);
        set_cfg(1, 0, 3'd2, 0, 0, 0, 0);
        send_rx(8'hD9, 1, 0, 0);
        send_rx(8'h44, 0, 1, 0);
        send_rx(8'h00, 0, 0, 1);
        send_rx(8'h6E, 0, 0, 0);   // R7 clean frame after break

        // R11 all polarities inverted
        set_cfg(0, 1, 3'd4, 1, 1, 1, 1);
        send_tx(8'h96, 0);
        send_rx(8'h96, 0, 0, 0);

        // random mix
        for (int it = 0; it < 30; it++) begin
            logic [7:0] d;
            logic [2:0] pm;
            pm = 3'($urandom_range(0, 4));
            set_cfg(1'($urandom), 1'($urandom), pm, 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
            d = 8'($urandom);
            send_tx(d, 1'b0);
            d = 8'($urandom) | 8'h01;
            send_rx(d, ($urandom % 4) == 0, ($urandom % 5) == 0, 1'b0);
        end

        finish_sim();
    end

endmodule